// File: doc/BRIEF.md
# Variable-Length Serial Tuning Word Receiver

This block takes a control word that arrives one bit at a time on a slow serial link, framed by an enable line, and turns it into held control outputs for a frequency synthesizer. A word can be 18, 19 or 34 bits long. The block counts the bits while enable is high. When enable drops it works out the frame type from that count, writes the fields into output registers, and raises a one-cycle load strobe for the next stage. That stage can use the strobe to move the word into its own double-latch scheme at a safe moment.

The serial clock, data and enable come from outside and are not tied to the system clock. They are passed through a synchronizer, and their edges are found in the system clock domain. A data bit is taken on each rising edge of the serial clock while enable is high. The first bit shifted in is always the top band-buffer bit.

The three frame types fill different fields:
- The 18-bit frame carries the band bits and a 14-bit divider value. The divider's top bit is cleared.
- The 19-bit frame carries the band bits and the full 15-bit divider value.
- The 34-bit frame carries the band bits, the full divider value and the test and feature bits. It is the only frame that can change the test and feature bits.

Top module: `tune_word_rx`

## Requirements
- R1: While `rst` is high and after it is released, every output register holds zero: band bits, divider ratio, pump-current select, comparator mode, test routing, and reference-divider select (zero selects the divide-by-512 setting). `load_stb` stays low.
- R2: An 18-bit frame loads the first 4 bits (first bit = band bit 3) into `band_out` and the next 14 bits (MSB first) into `div_ratio[13:0]`. It forces `div_ratio[14]` to 0.
- R3: A 19-bit frame loads the first 4 bits into `band_out` and the next 15 bits (MSB first) into `div_ratio`.
- R4: A 34-bit frame loads the band bits and the 15 divider bits in the same way as R3. The next 7 bits, in shift order, are:
  - an ignored bit;
  - `ref_div_sel`;
  - `test_route`;
  - an ignored bit;
  - `pc_mode[1]`;
  - `pc_mode[0]`;
  - `pump_hi`.
  The last 8 bits are ignored.
- R5: 18-bit and 19-bit frames leave `pump_hi`, `pc_mode`, `test_route` and `ref_div_sel` unchanged.
- R6: A frame whose bit count is not 18, 19 or 34 changes no output and produces no `load_stb`.
- R7: Each valid frame produces exactly one `load_stb` pulse, one system-clock cycle wide. The pulse is high in the same cycle that the new values first appear on the outputs.
- R8: Rising edges of `ser_clk` while `ser_en` is low shift no bit and add nothing to the next frame's count.
- R9: A frame with more than 34 bits is treated as invalid, as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, sampled on rising `ser_clk` |
| ser_en | input | 1 | Frame enable; a falling edge ends the frame |
| band_out | output | 4 | Band-buffer control bits |
| div_ratio | output | 15 | Programmable divider ratio |
| pump_hi | output | 1 | Charge-pump current select |
| pc_mode | output | 2 | Phase comparator output mode |
| test_route | output | 1 | Route internal test frequencies to band outputs |
| ref_div_sel | output | 1 | Reference divider select (0 = 512, 1 = 1024) |
| load_stb | output | 1 | One-cycle strobe after a valid frame |

## Verification
The hardest situation to reach from the ports is a test or feature bit keeping its value across shorter frames. To observe it, the bench first sends a 34-bit frame with mixed test bits, including set ignored bits. It then sends 19-bit and 18-bit frames and a malformed frame, and checks after each one that the test outputs have not moved. For the cleared top divider bit, the bench sends a 19-bit frame with that bit set and follows it with an 18-bit frame. The bench also toggles the serial clock while enable is low, so that a miscounted frame would show up as a rejected load.

// File: rtl/tune_pkg.sv
package tune_pkg;
  localparam int BAND_W  = 4;
  localparam int RATIO_W = 15;

  typedef enum logic [1:0] {
    FR_NONE  = 2'd0,
    FR_SHORT = 2'd1,
    FR_MID   = 2'd2,
    FR_LONG  = 2'd3
  } frame_kind_t;

  typedef struct packed {
    logic [BAND_W-1:0]  band;
    logic [RATIO_W-1:0] ratio;
    logic               pump_hi;
    logic [1:0]         pc_mode;
    logic               test_route;
    logic               ref_sel;
  } tune_word_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '0;
    else     st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[i] <= '0;
      else     st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter #(
  parameter int LONG_LEN = 34,
  parameter int CW       = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk_s,
  input  logic                sdat_s,
  input  logic                en_s,
  output logic [LONG_LEN-1:0] sr,
  output logic [CW-1:0]       cnt,
  output logic                frame_end
);
  localparam logic [CW-1:0] CAP = CW'(LONG_LEN + 1);

  logic sclk_d, en_d;
  logic take_bit, frame_start;

  assign take_bit    = sclk_s & ~sclk_d & en_s;
  assign frame_start = en_s & ~en_d;
  assign frame_end   = en_d & ~en_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      en_d   <= 1'b0;
      sr     <= '0;
      cnt    <= '0;
    end else begin
      sclk_d <= sclk_s;
      en_d   <= en_s;
      if (frame_start) begin
        cnt <= '0;
      end else if (take_bit) begin
        sr <= {sr[LONG_LEN-2:0], sdat_s};
        if (cnt != CAP) cnt <= cnt + 1'b1;
      end
    end
  end

  // R9: the bit counter saturates one above the longest legal frame
  assert_cnt_cap_R9: assert property (@(posedge clk) disable iff (rst)
    cnt <= CAP);

  // R8: the count only moves while enable is high (or is cleared at start)
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!en_s && !en_d) |=> $stable(cnt));
endmodule

// File: rtl/tw_decoder.sv
module tw_decoder
  import tune_pkg::*;
#(
  parameter int SHORT_LEN = 18,
  parameter int MID_LEN   = 19,
  parameter int LONG_LEN  = 34,
  parameter int CW        = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_end,
  input  logic [LONG_LEN-1:0] sr,
  input  logic [CW-1:0]       cnt,
  output tune_word_t          word,
  output logic                load_stb
);
  localparam int TAIL = LONG_LEN - BAND_W - RATIO_W;

  frame_kind_t kind;
  tune_word_t  nxt;

  always_comb begin
    if      (cnt == CW'(SHORT_LEN)) kind = FR_SHORT;
    else if (cnt == CW'(MID_LEN))   kind = FR_MID;
    else if (cnt == CW'(LONG_LEN))  kind = FR_LONG;
    else                            kind = FR_NONE;
  end

  always_comb begin
    nxt = word;
    unique case (kind)
      FR_SHORT: begin
        nxt.band  = sr[SHORT_LEN-1 -: BAND_W];
        nxt.ratio = {1'b0, sr[RATIO_W-2:0]};
      end
      FR_MID: begin
        nxt.band  = sr[MID_LEN-1 -: BAND_W];
        nxt.ratio = sr[RATIO_W-1:0];
      end
      FR_LONG: begin
        nxt.band       = sr[LONG_LEN-1 -: BAND_W];
        nxt.ratio      = sr[LONG_LEN-BAND_W-1 -: RATIO_W];
        nxt.ref_sel    = sr[TAIL-2];
        nxt.test_route = sr[TAIL-3];
        nxt.pc_mode    = {sr[TAIL-5], sr[TAIL-6]};
        nxt.pump_hi    = sr[TAIL-7];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word     <= '0;
      load_stb <= 1'b0;
    end else begin
      load_stb <= frame_end && (kind != FR_NONE);
      if (frame_end && kind != FR_NONE) word <= nxt;
    end
  end

  // R7: strobe is one cycle wide
  assert_stb_single_R7: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> !load_stb);

  // R6: outputs move only at the end of a frame
  assert_hold_between_R6: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(word));

  // R6: rejected frames leave everything untouched
  assert_reject_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_end && kind == FR_NONE) |=> (!load_stb && $stable(word)));

  // R2: short frames clear the divider MSB
  assert_short_msb_R2: assert property (@(posedge clk) disable iff (rst)
    (frame_end && kind == FR_SHORT) |=> !word.ratio[RATIO_W-1]);

  // R5: short and mid frames keep test bits
  assert_test_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (frame_end && (kind == FR_SHORT || kind == FR_MID)) |=>
      ($stable(word.pump_hi) && $stable(word.pc_mode) &&
       $stable(word.test_route) && $stable(word.ref_sel)));
endmodule

// File: rtl/tune_word_rx.sv
module tune_word_rx
  import tune_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_LEN   = 18,
  parameter int MID_LEN     = 19,
  parameter int LONG_LEN    = 34
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_en,
  output logic [BAND_W-1:0]  band_out,
  output logic [RATIO_W-1:0] div_ratio,
  output logic               pump_hi,
  output logic [1:0]         pc_mode,
  output logic               test_route,
  output logic               ref_div_sel,
  output logic               load_stb
);
  localparam int CW = $clog2(LONG_LEN + 2);

  logic [2:0]          raw, synced;
  logic [LONG_LEN-1:0] sr;
  logic [CW-1:0]       cnt;
  logic                frame_end;
  tune_word_t          word;

  assign raw = {ser_en, ser_data, ser_clk};

  tw_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (synced)
  );

  tw_shifter #(.LONG_LEN(LONG_LEN), .CW(CW)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .sclk_s    (synced[0]),
    .sdat_s    (synced[1]),
    .en_s      (synced[2]),
    .sr        (sr),
    .cnt       (cnt),
    .frame_end (frame_end)
  );

  tw_decoder #(
    .SHORT_LEN (SHORT_LEN),
    .MID_LEN   (MID_LEN),
    .LONG_LEN  (LONG_LEN),
    .CW        (CW)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .frame_end (frame_end),
    .sr        (sr),
    .cnt       (cnt),
    .word      (word),
    .load_stb  (load_stb)
  );

  assign band_out    = word.band;
  assign div_ratio   = word.ratio;
  assign pump_hi     = word.pump_hi;
  assign pc_mode     = word.pc_mode;
  assign test_route  = word.test_route;
  assign ref_div_sel = word.ref_sel;
endmodule

// File: tb/tb_tune_word_rx.sv
`timescale 1ns/1ps
module tb_tune_word_rx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b0;
  logic [3:0]  band_out;
  logic [14:0] div_ratio;
  logic        pump_hi, test_route, ref_div_sel, load_stb;
  logic [1:0]  pc_mode;

  int checks = 0, failures = 0;
  int stb_cnt = 0, stb_wide = 0;
  logic stb_prev = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tune_word_rx dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_en(ser_en), .band_out(band_out), .div_ratio(div_ratio),
    .pump_hi(pump_hi), .pc_mode(pc_mode), .test_route(test_route),
    .ref_div_sel(ref_div_sel), .load_stb(load_stb)
  );

  always @(posedge clk) begin
    stb_prev <= load_stb;
    if (load_stb) stb_cnt <= stb_cnt + 1;
    if (load_stb && stb_prev) stb_wide <= stb_wide + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [63:0] bits, input int n);
    ser_en = 1'b1;
    wait_clk(6);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = bits[i];
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
    end
    wait_clk(4);
    ser_en = 1'b0;
    wait_clk(10);
  endtask

  task automatic t_reset;
    wait_clk(3);
    check("R1 band", band_out, 0);
    check("R1 ratio", div_ratio, 0);
    check("R1 test", {pump_hi, pc_mode, test_route, ref_div_sel}, 0);
    check("R1 stb", load_stb, 0);
    rst = 1'b0;
    wait_clk(5);
    check("R1 after release", {band_out, div_ratio, pump_hi, pc_mode, test_route, ref_div_sel}, 0);
    check("R1 no stb", stb_cnt, 0);
  endtask

  task automatic t_mid;
    int s0 = stb_cnt;
    send_frame({45'd0, 4'h5, 15'h4321}, 19);
    check("R3 band", band_out, 4'h5);
    check("R3 ratio", div_ratio, 15'h4321);
    check("R7 one stb", stb_cnt - s0, 1);
  endtask

  task automatic t_short;
    int s0 = stb_cnt;
    send_frame({46'd0, 4'hA, 14'h2ABC}, 18);
    check("R2 band", band_out, 4'hA);
    check("R2 ratio msb clear", div_ratio, 15'h2ABC);
    check("R7 one stb", stb_cnt - s0, 1);
  endtask

  task automatic t_long;
    // Y6=1 T5=1 T4=1 Y3=1 T2=1 T1=0 T0=1, X=FF
    send_frame({30'd0, 4'hC, 15'h1234, 7'b1111101, 8'hFF}, 34);
    check("R4 band", band_out, 4'hC);
    check("R4 ratio", div_ratio, 15'h1234);
    check("R4 ref_sel", ref_div_sel, 1);
    check("R4 test_route", test_route, 1);
    check("R4 pc_mode", pc_mode, 2'b10);
    check("R4 pump_hi", pump_hi, 1);
  endtask

  task automatic t_keep;
    send_frame({45'd0, 4'h3, 15'h7FFF}, 19);
    check("R5 test bits after mid", {pump_hi, pc_mode, test_route, ref_div_sel}, 5'b1_10_1_1);
    check("R3 ratio full", div_ratio, 15'h7FFF);
    send_frame({46'd0, 4'h6, 14'h0011}, 18);
    check("R5 test bits after short", {pump_hi, pc_mode, test_route, ref_div_sel}, 5'b1_10_1_1);
    check("R2 msb forced", div_ratio, 15'h0011);
  endtask

  task automatic t_bad;
    int s0 = stb_cnt;
    send_frame({44'd0, 20'hFFFFF}, 20);
    check("R6 20-bit ignored", {band_out, div_ratio}, {4'h6, 15'h0011});
    send_frame({47'd0, 17'h1FFFF}, 17);
    check("R6 17-bit ignored", {band_out, div_ratio}, {4'h6, 15'h0011});
    send_frame({29'd0, 35'h7FFFFFFFF}, 35);
    check("R9 35-bit ignored", {band_out, div_ratio, pump_hi, pc_mode, test_route, ref_div_sel},
          {4'h6, 15'h0011, 5'b1_10_1_1});
    check("R6 no stb", stb_cnt - s0, 0);
  endtask

  task automatic t_gate;
    int s0 = stb_cnt;
    for (int k = 0; k < 5; k++) begin
      ser_data = 1'b1;
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
    end
    send_frame({45'd0, 4'h9, 15'h0ACE}, 19);
    check("R8 frame intact", {band_out, div_ratio}, {4'h9, 15'h0ACE});
    check("R8 stb", stb_cnt - s0, 1);
    // long frame with all test bits clear, ignored bits set
    send_frame({30'd0, 4'h0, 15'h0001, 7'b1001000, 8'hA5}, 34);
    check("R4 clear test bits", {pump_hi, pc_mode, test_route, ref_div_sel}, 0);
    check("R7 never wide", stb_wide, 0);
  endtask

  initial begin
    t_reset;
    t_mid;
    t_short;
    t_long;
    t_keep;
    t_bad;
    t_gate;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule